// File: doc/BRIEF.md
# Reset Cause and Wake-up Controller

This block turns several reset sources into one system reset for a small controller core. It also keeps two status flags that firmware reads after a restart to learn why the core restarted. The reset sources are power-up, a supply-droop detector, an optional active-low board reset pin and watchdog expiry. Any of the asynchronous sources pulls the system reset low at once. Release passes through a two-stage synchroniser and then waits a set number of watchdog-clock ticks.

The same block owns the low-power state. A sleep strobe from the core puts it to sleep. It leaves sleep in one of two ways. The first is a level change on a port-B pin whose wake enable is set. The second is a watchdog expiry when the watchdog-wake mode is selected. That path waits a stabilisation interval, long or short, before it signals the wake. While watchdog-wake mode is active, the wake enable of the topmost port-B pin is ignored.

The two flags are a timeout flag and a power-down flag. Their values encode the cause of the last restart or wake.

Top module: `rst_wake_ctrl`

## Requirements
- R1: While `por_n` is low, `lvd_trip` is high, or `rst_pin_n` is low with `pin_rst_en` high, `sys_rst_n` is low. It goes low without waiting for a clock edge.
- R2: Once all asynchronous sources are inactive, and with `wdt_tick` high every cycle, `sys_rst_n` is still low at the (RST_DELAY+1)-th rising edge and is high from the (RST_DELAY+2)-th edge on.
- R3: With `pin_rst_en` low, `rst_pin_n` has no effect on `sys_rst_n`.
- R4: A `wdt_ovf` pulse with `wdt_en` high, while awake, drives `sys_rst_n` low at the next edge and sets timeout flag 0, power-down flag 1. Release follows RST_DELAY+3 edges after the pulse edge. With `wdt_en` low, `wdt_ovf` is ignored.
- R5: Power-up or supply-droop reset sets timeout flag 1, power-down flag 1.
- R6: A pin reset while asleep clears `sleeping` three edges after the pin falls and sets timeout 1, power-down 0. A pin reset while awake leaves both flags unchanged.
- R7: A `sleep_req` strobe sets `sleeping` and flags 1/0 at the next edge. A `clrwdt_req` strobe sets flags 1/1. Both strobes are ignored while `sys_rst_n` is low.
- R8: While asleep, a level change on a port-B pin whose `wake_en` bit is set gives a one-cycle `wake_pulse` at the third edge after the change. At that same edge `sleeping` clears and flags become 1/0. A change on a pin with its enable clear does nothing.
- R9: A watchdog expiry while asleep, with watchdog-wake mode off, resets the system and sets flags 0/0.
- R10: Watchdog-wake mode is `iwdt_sel` and `wdt_en` both high. In this mode an expiry while asleep causes no reset and sets flags 0/0. `wake_pulse` then comes STAB_TICKS ticks later when `stab_short` is 0, or STAB_TICKS/2 ticks later when it is 1.
- R11: In watchdog-wake mode, bit 7 of `wake_en` is ignored. A change on `port_b[7]` does not wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (watchdog-clock domain) |
| por_n | input | 1 | Power-up reset, active low |
| lvd_trip | input | 1 | Supply-droop detector output, active high |
| rst_pin_n | input | 1 | Board reset pin, active low |
| pin_rst_en | input | 1 | Configuration: the pin acts as a reset |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_ovf | input | 1 | Watchdog expiry pulse |
| wdt_tick | input | 1 | Tick strobe timing the reset delay and the stabilisation interval |
| sleep_req | input | 1 | Sleep strobe from the core |
| clrwdt_req | input | 1 | Watchdog-clear strobe from the core |
| iwdt_sel | input | 1 | Select watchdog-wake mode |
| stab_short | input | 1 | Use the short stabilisation interval |
| port_b | input | 8 | Port-B pin levels |
| wake_en | input | 8 | Per-pin wake enables |
| sys_rst_n | output | 1 | Synchronised system reset, active low |
| wake_pulse | output | 1 | One-cycle wake indication |
| sleeping | output | 1 | Core is in the low-power state |
| flag_to | output | 1 | Timeout flag |
| flag_pd | output | 1 | Power-down flag |

## Verification
Each result has a fixed latency:
- Asynchronous resets show on `sys_rst_n` before the next edge.
- Strobes and watchdog expiries update the flags and `sleeping` at the first edge.
- Pin changes and pin resets take effect at the third edge, after two synchroniser stages and one compare stage.
- Reset release lands RST_DELAY+2 edges after the last source clears.
- A watchdog-wake pulse lands one edge plus the chosen interval after the expiry.

The scoreboard stamps each expected value with the absolute cycle number at which it is due. It compares that value one time unit after that rising edge. Many checks also sample the cycle just before the change, so a result that comes one cycle early or late is caught.

// File: rtl/rwc_pkg.sv
package rwc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SLEEP = 2'd1,
    ST_STAB  = 2'd2
  } slp_state_e;
endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         arst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/rwc_rst_gen.sv
module rwc_rst_gen #(
  parameter int RST_DELAY = 16
) (
  input  logic clk,
  input  logic async_rst,
  input  logic wdt_rst_req,
  input  logic wdt_tick,
  output logic sys_rst_n
);
  localparam int DW = $clog2(RST_DELAY + 1);
  localparam logic [DW-1:0] LAST = DW'(RST_DELAY - 1);

  logic          s1_q, s2_q, done_q;
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk or posedge async_rst) begin
    if (async_rst) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else if (wdt_rst_req) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
      if (s2_q && !done_q && wdt_tick) begin
        if (cnt_q == LAST) done_q <= 1'b1;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign sys_rst_n = done_q;

  // R2: release only after the synchroniser and a counted tick
  assert_release_after_sync_R2: assert property (@(posedge clk) disable iff (async_rst)
    $rose(done_q) |-> $past(s2_q && wdt_tick));

  // R4: watchdog request forces reset at the next edge
  assert_wdt_forces_reset_R4: assert property (@(posedge clk) disable iff (async_rst)
    wdt_rst_req |=> !sys_rst_n);
endmodule

// File: rtl/rwc_wake.sv
module rwc_wake
  import rwc_pkg::*;
#(
  parameter int PORT_W        = 8,
  parameter int IWDT_MASK_BIT = 7,
  parameter int STAB_TICKS    = 12
) (
  input  logic              clk,
  input  logic              cold_rst,
  input  logic [PORT_W-1:0] pb_sync,
  input  logic [PORT_W-1:0] wake_en,
  input  logic              iwdt_mode,
  input  logic              stab_short,
  input  logic              wdt_tick,
  input  logic              wdt_hit,
  input  logic              pin_rst_hit,
  input  logic              sleep_go,
  output slp_state_e        state,
  output logic              pin_wake,
  output logic              wdt_rst_req,
  output logic              wake_pulse
);
  localparam int SHORT_TICKS = (STAB_TICKS / 2 > 0) ? STAB_TICKS / 2 : 1;
  localparam int CW = $clog2(STAB_TICKS + 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(STAB_TICKS - 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [PORT_W-1:0] TOP_BIT = {{(PORT_W-1){1'b0}}, 1'b1} << IWDT_MASK_BIT;

  logic [PORT_W-1:0] pb_prev, eff_en, pb_chg;
  logic [CW-1:0]     cnt_q;

  for (genvar i = 0; i < PORT_W; i++) begin : g_en
    if (i == IWDT_MASK_BIT) begin : g_masked
      assign eff_en[i] = wake_en[i] & ~iwdt_mode;
    end else begin : g_plain
      assign eff_en[i] = wake_en[i];
    end
  end

  assign pb_chg      = pb_sync ^ pb_prev;
  assign pin_wake    = (state == ST_SLEEP) && |(pb_chg & eff_en);
  assign wdt_rst_req = wdt_hit && !((state == ST_SLEEP) && iwdt_mode);

  always_ff @(posedge clk or posedge cold_rst) begin
    if (cold_rst) begin
      state      <= ST_RUN;
      cnt_q      <= '0;
      wake_pulse <= 1'b0;
      pb_prev    <= '0;
    end else begin
      pb_prev    <= pb_sync;
      wake_pulse <= 1'b0;
      if (pin_rst_hit || wdt_rst_req) begin
        state <= ST_RUN;
      end else begin
        unique case (state)
          ST_RUN: if (sleep_go) state <= ST_SLEEP;
          ST_SLEEP: begin
            if (pin_wake) begin
              state      <= ST_RUN;
              wake_pulse <= 1'b1;
            end else if (wdt_hit) begin
              state <= ST_STAB;
              cnt_q <= '0;
            end
          end
          ST_STAB: begin
            if (wdt_tick) begin
              if (cnt_q == (stab_short ? SHORT_LAST : LONG_LAST)) begin
                state      <= ST_RUN;
                wake_pulse <= 1'b1;
              end else begin
                cnt_q <= cnt_q + 1'b1;
              end
            end
          end
          default: state <= ST_RUN;
        endcase
      end
    end
  end

  // R8: wake indication lasts a single cycle
  assert_wake_single_R8: assert property (@(posedge clk) disable iff (cold_rst)
    wake_pulse |=> !wake_pulse);

  // R11: top pin alone never wakes in watchdog-wake mode
  assert_top_pin_masked_R11: assert property (@(posedge clk) disable iff (cold_rst)
    (state == ST_SLEEP && iwdt_mode && (pb_chg & ~TOP_BIT) == '0 && !pin_rst_hit && !wdt_hit)
    |=> state == ST_SLEEP);
endmodule

// File: rtl/rwc_flags.sv
module rwc_flags (
  input  logic clk,
  input  logic cold_rst,
  input  logic asleep,
  input  logic pin_rst_hit,
  input  logic wdt_hit,
  input  logic pin_wake,
  input  logic clrwdt_go,
  input  logic sleep_go,
  output logic flag_to,
  output logic flag_pd
);
  always_ff @(posedge clk or posedge cold_rst) begin
    if (cold_rst) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
    end else if (pin_rst_hit) begin
      if (asleep) begin
        flag_to <= 1'b1;
        flag_pd <= 1'b0;
      end
    end else if (wdt_hit) begin
      flag_to <= 1'b0;
      flag_pd <= ~asleep;
    end else if (pin_wake) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b0;
    end else if (clrwdt_go) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b1;
    end else if (sleep_go && !asleep) begin
      flag_to <= 1'b1;
      flag_pd <= 1'b0;
    end
  end

  // R4, R9: any effective watchdog expiry clears the timeout flag
  assert_wdt_clears_to_R4: assert property (@(posedge clk) disable iff (cold_rst)
    (wdt_hit && !pin_rst_hit) |=> !flag_to);

  // R6: pin reset while awake keeps the flags
  assert_pin_run_keeps_R6: assert property (@(posedge clk) disable iff (cold_rst)
    (pin_rst_hit && !asleep) |=> $stable({flag_to, flag_pd}));
endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl
  import rwc_pkg::*;
#(
  parameter int RST_DELAY     = 16,
  parameter int STAB_TICKS    = 12,
  parameter int PORT_W        = 8,
  parameter int IWDT_MASK_BIT = 7
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              lvd_trip,
  input  logic              rst_pin_n,
  input  logic              pin_rst_en,
  input  logic              wdt_en,
  input  logic              wdt_ovf,
  input  logic              wdt_tick,
  input  logic              sleep_req,
  input  logic              clrwdt_req,
  input  logic              iwdt_sel,
  input  logic              stab_short,
  input  logic [PORT_W-1:0] port_b,
  input  logic [PORT_W-1:0] wake_en,
  output logic              sys_rst_n,
  output logic              wake_pulse,
  output logic              sleeping,
  output logic              flag_to,
  output logic              flag_pd
);
  logic              cold_rst, pin_rst_lvl, async_rst;
  logic              pin_rst_hit, wdt_hit, iwdt_mode;
  logic              sleep_go, clrwdt_go, pin_wake, wdt_rst_req;
  logic [PORT_W-1:0] pb_sync;
  slp_state_e        state;

  assign cold_rst    = ~por_n | lvd_trip;
  assign pin_rst_lvl = pin_rst_en & ~rst_pin_n;
  assign async_rst   = cold_rst | pin_rst_lvl;
  assign wdt_hit     = wdt_ovf & wdt_en;
  assign iwdt_mode   = iwdt_sel & wdt_en;
  assign sleep_go    = sleep_req & sys_rst_n;
  assign clrwdt_go   = clrwdt_req & sys_rst_n;
  assign sleeping    = (state != ST_RUN);

  rwc_sync #(.W(1)) u_pin_sync (
    .clk(clk), .arst(cold_rst), .d(pin_rst_lvl), .q(pin_rst_hit)
  );

  rwc_sync #(.W(PORT_W)) u_pb_sync (
    .clk(clk), .arst(cold_rst), .d(port_b), .q(pb_sync)
  );

  rwc_rst_gen #(.RST_DELAY(RST_DELAY)) u_rst (
    .clk(clk), .async_rst(async_rst), .wdt_rst_req(wdt_rst_req),
    .wdt_tick(wdt_tick), .sys_rst_n(sys_rst_n)
  );

  rwc_wake #(
    .PORT_W(PORT_W), .IWDT_MASK_BIT(IWDT_MASK_BIT), .STAB_TICKS(STAB_TICKS)
  ) u_wake (
    .clk(clk), .cold_rst(cold_rst), .pb_sync(pb_sync), .wake_en(wake_en),
    .iwdt_mode(iwdt_mode), .stab_short(stab_short), .wdt_tick(wdt_tick),
    .wdt_hit(wdt_hit), .pin_rst_hit(pin_rst_hit), .sleep_go(sleep_go),
    .state(state), .pin_wake(pin_wake), .wdt_rst_req(wdt_rst_req),
    .wake_pulse(wake_pulse)
  );

  rwc_flags u_flags (
    .clk(clk), .cold_rst(cold_rst), .asleep(sleeping), .pin_rst_hit(pin_rst_hit),
    .wdt_hit(wdt_hit), .pin_wake(pin_wake), .clrwdt_go(clrwdt_go),
    .sleep_go(sleep_go), .flag_to(flag_to), .flag_pd(flag_pd)
  );
endmodule

// File: tb/sim_rst_wake_ctrl.sv
module sim_rst_wake_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RD = 16;
  localparam int ST = 12;
  localparam int SH = ST / 2;
  localparam logic [4:0] MR = 5'b10000, MW = 5'b01000, MS = 5'b00100,
                         MF = 5'b00011, ALL = 5'b11111;

  logic clk = 1'b0;
  logic por_n = 1'b0, lvd_trip = 1'b0, rst_pin_n = 1'b1, pin_rst_en = 1'b1;
  logic wdt_en = 1'b1, wdt_ovf = 1'b0, wdt_tick = 1'b1;
  logic sleep_req = 1'b0, clrwdt_req = 1'b0, iwdt_sel = 1'b0, stab_short = 1'b0;
  logic [7:0] port_b = 8'h00, wake_en = 8'h00;
  logic sys_rst_n, wake_pulse, sleeping, flag_to, flag_pd;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rst_wake_ctrl #(.RST_DELAY(RD), .STAB_TICKS(ST)) u0 (
    .clk(clk), .por_n(por_n), .lvd_trip(lvd_trip), .rst_pin_n(rst_pin_n),
    .pin_rst_en(pin_rst_en), .wdt_en(wdt_en), .wdt_ovf(wdt_ovf), .wdt_tick(wdt_tick),
    .sleep_req(sleep_req), .clrwdt_req(clrwdt_req), .iwdt_sel(iwdt_sel),
    .stab_short(stab_short), .port_b(port_b), .wake_en(wake_en),
    .sys_rst_n(sys_rst_n), .wake_pulse(wake_pulse), .sleeping(sleeping),
    .flag_to(flag_to), .flag_pd(flag_pd)
  );

  typedef struct {
    int         cyc;
    logic [4:0] mask;
    logic [4:0] val;
    string      tag;
  } exp_t;

  exp_t sbq[$];
  int   cyc = 0, n_cmp = 0, n_bad = 0;
  bit   finished = 1'b0;
  wire [4:0] obs = {sys_rst_n, wake_pulse, sleeping, flag_to, flag_pd};

  // monitor: obs = {sys_rst_n, wake_pulse, sleeping, flag_to, flag_pd}
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        n_cmp++;
        if ((obs & e.mask) !== (e.val & e.mask)) begin
          n_bad++;
          $display("FAIL %s at cycle %0d: actual %b expected %b (mask %b)",
                   e.tag, cyc, obs & e.mask, e.val & e.mask, e.mask);
        end
      end
    end
  end

  task automatic expect_at(int k, logic [4:0] m, logic [4:0] v, string tag);
    exp_t e;
    e.cyc = cyc + k; e.mask = m; e.val = v; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; idle(1); sleep_req = 1'b0;
  endtask

  task automatic pulse_ovf();
    wdt_ovf = 1'b1; idle(1); wdt_ovf = 1'b0;
  endtask

  initial begin
    idle(3);
    expect_at(1, ALL, 5'b00011, "R1 R5 power-up hold");
    idle(2);
    expect_at(1 + RD, MR, 5'b00000, "R2 still held");
    expect_at(2 + RD, ALL, 5'b10011, "R2 release");
    por_n = 1'b1;
    idle(RD + 6);

    wdt_en = 1'b0;
    expect_at(1, ALL, 5'b10011, "R4 overflow ignored when disabled");
    expect_at(3, ALL, 5'b10011, "R4 overflow ignored when disabled");
    pulse_ovf();
    idle(4);
    wdt_en = 1'b1;
    idle(1);

    expect_at(1, ALL, 5'b00001, "R4 watchdog reset awake");
    expect_at(2 + RD, MR, 5'b00000, "R4 still held");
    expect_at(3 + RD, MR | MF, 5'b10001, "R4 release");
    pulse_ovf();
    idle(RD + 5);

    expect_at(1, MR | MS | MF, 5'b00001, "R1 pin async, R6 awake flags kept");
    rst_pin_n = 1'b0;
    idle(1);
    expect_at(1, MS | MF, 5'b00001, "R7 sleep ignored in reset");
    expect_at(4, MF, 5'b00001, "R6 awake flags kept");
    pulse_sleep();
    idle(4);
    expect_at(1 + RD, MR, 5'b00000, "R2 pin release held");
    expect_at(2 + RD, MR, 5'b10000, "R2 pin release");
    rst_pin_n = 1'b1;
    idle(RD + 5);

    expect_at(1, MF, 5'b00011, "R7 clear-watchdog");
    clrwdt_req = 1'b1; idle(1); clrwdt_req = 1'b0;
    idle(2);

    pin_rst_en = 1'b0;
    idle(1);
    expect_at(1, MR, 5'b10000, "R3 pin disabled");
    expect_at(5, MR, 5'b10000, "R3 pin disabled");
    rst_pin_n = 1'b0;
    idle(6);
    rst_pin_n = 1'b1;
    idle(2);
    pin_rst_en = 1'b1;
    idle(2);

    wake_en = 8'h01;
    idle(2);
    expect_at(1, ALL, 5'b10110, "R7 sleep entry");
    pulse_sleep();
    idle(2);
    expect_at(4, MS | MW, 5'b00100, "R8 disabled pin no wake");
    port_b = 8'h02;
    idle(6);
    expect_at(2, MW | MS, 5'b00100, "R8 not yet awake");
    expect_at(3, ALL, 5'b11010, "R8 pin-change wake");
    expect_at(4, MW, 5'b00000, "R8 pulse one cycle");
    port_b = 8'h03;
    idle(6);

    expect_at(1, MS, 5'b00100, "R7 sleep entry");
    pulse_sleep();
    idle(2);
    expect_at(1, MR | MS | MF, 5'b00000, "R9 watchdog in sleep resets");
    pulse_ovf();
    idle(RD + 6);

    pulse_sleep();
    idle(2);
    expect_at(1, MR, 5'b00000, "R1 pin during sleep");
    expect_at(2, MS, 5'b00100, "R6 still asleep");
    expect_at(3, MS | MF, 5'b00010, "R6 pin reset in sleep");
    rst_pin_n = 1'b0;
    idle(5);
    rst_pin_n = 1'b1;
    idle(RD + 5);

    iwdt_sel = 1'b1;
    wake_en = 8'h80;
    idle(2);
    pulse_sleep();
    idle(2);
    expect_at(5, MS | MW, 5'b00100, "R11 top pin masked");
    port_b = port_b ^ 8'h80;
    idle(6);
    expect_at(1, ALL, 5'b10100, "R10 no reset, flags 0/0");
    expect_at(ST, MW | MS, 5'b00100, "R10 long not yet");
    expect_at(ST + 1, ALL, 5'b11000, "R10 long wake");
    expect_at(ST + 2, MW, 5'b00000, "R10 pulse one cycle");
    pulse_ovf();
    idle(ST + 5);

    stab_short = 1'b1;
    pulse_sleep();
    idle(2);
    expect_at(SH, MW | MS, 5'b00100, "R10 short not yet");
    expect_at(SH + 1, MW | MS, 5'b01000, "R10 short wake");
    pulse_ovf();
    idle(SH + 5);

    expect_at(1, MR | MF, 5'b00011, "R5 droop reset");
    lvd_trip = 1'b1;
    idle(3);
    lvd_trip = 1'b0;
    idle(RD + 5);

    wait (sbq.size() == 0);
    idle(2);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule